// File: doc/BRIEF.md
# Write-Only Two-Wire Control Register Slave

This block is a write-only slave on a two-wire serial bus. It fills a small bank of eight-bit control registers that drive clock enables, output mode and frequency selection elsewhere on the chip. The serial clock and data lines are sampled with a faster system clock. Start and stop conditions are recovered from the sampled lines. Each byte is received MSB first, and every byte the block accepts is acknowledged by pulling the data line low.

A transfer opens with the device address byte, which must be the exact write value 0xD2. Two framing bytes come next, a command byte and a count byte. Both are acknowledged and their contents are discarded. After them, data bytes are stored in order starting at register 0. There is no subaddress, so reaching a later register means resending every earlier one. Up to ten bytes after the address are accepted. While the active-low power-down input is asserted, all bus activity is ignored and the register contents are kept. Only the true power-on reset loads the default values.

Top module: `wo_ctl_slave`

## Requirements
- R1: After power-on reset the bank holds register 0 = 0x0C, 1 = 0xCF, 2 = 0x7F, 3 = 0xFF, 4 = 0x00, 5 = 0x37, 6 = 0x00, 7 = 0x07, packed with register k in bits 8k+7..8k of `ctl_regs`, and `sda_pull` is low.
- R2: A falling data edge while the clock is high starts a transfer. A rising data edge while the clock is high ends it, after which bytes get no acknowledge until the next start.
- R3: Only an address byte of 0xD2 (address 0x69, write) is acknowledged. Any other address, including the read value 0xD3, gets no acknowledge, and the rest of that transfer stores nothing.
- R4: `sda_pull` is high from the clock fall after the eighth bit of an accepted byte until the clock fall after the ninth clock, and low at every other time.
- R5: The first two bytes after the address are acknowledged and change no register.
- R6: Data bytes after the two framing bytes are written to registers 0, 1, 2, … in arrival order. A transfer that stops early leaves the higher registers unchanged.
- R7: Only ten bytes after the address are acknowledged. Further bytes in the same transfer are neither acknowledged nor stored.
- R8: While `pwr_dn_n` is low, bus activity produces no acknowledge and no register change, and the registers keep their values. Once `pwr_dn_n` returns high, the next transfer works normally.
- R9: A start condition in the middle of a byte abandons that byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| por_n | input | 1 | True power-on reset, active low; loads defaults |
| pwr_dn_n | input | 1 | Power-down, active low; freezes the interface |
| scl | input | 1 | Serial bus clock line |
| sda | input | 1 | Serial bus data line, as seen on the wire |
| sda_pull | output | 1 | High to pull the data line low (acknowledge) |
| ctl_regs | output | 64 | Register bank, register k in bits 8k+7..8k |

## Verification
Some properties are checked on every cycle. The acknowledge never rises while the sampled clock is high. Power-down releases the acknowledge and holds the bank frozen. A stop condition always leaves the receiver idle. A register changes only while the byte counter is in the data window.

Other behaviour only shows up in the bench scenarios. These cover matching the exact address value, discarding the framing bytes, writes landing in order from register 0, rejecting the eleventh byte, recovering after power-down, and a restart in mid-byte. A behavioural model checks them against the outputs on every settled clock.

// File: rtl/wo_ctl_slave.sv
module wo_ctl_slave #(
  parameter int NREG = 8,
  parameter int FRAME = 2,
  parameter logic [7:0] DEV_ADDR = 8'hD2,
  parameter logic [NREG*8-1:0] RST_VAL = 64'h07_00_37_00_FF_7F_CF_0C
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pwr_dn_n,
  input  logic              scl,
  input  logic              sda,
  output logic              sda_pull,
  output logic [NREG*8-1:0] ctl_regs
);
  localparam int MAXB = FRAME + NREG;
  localparam int CW = $clog2(MAXB + 2);
  localparam logic [CW-1:0] SAT = CW'(MAXB + 1);

  logic       scl_m, scl_s, scl_p, sda_m, sda_s, sda_p;
  logic       active;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [CW-1:0] bytecnt;

  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire is_addr   = (bytecnt == '0);
  wire in_window = (bytecnt != '0) && (int'(bytecnt) <= MAXB);
  wire accept    = is_addr ? (shreg == DEV_ADDR) : in_window;
  wire do_store  = accept && (int'(bytecnt) > FRAME);
  wire [CW-1:0] widx = bytecnt - CW'(FRAME + 1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      {scl_m, scl_s, scl_p} <= 3'b111;
      {sda_m, sda_s, sda_p} <= 3'b111;
      active   <= 1'b0;
      bitcnt   <= '0;
      shreg    <= '0;
      bytecnt  <= '0;
      sda_pull <= 1'b0;
      ctl_regs <= RST_VAL;
    end else begin
      {scl_p, scl_s, scl_m} <= {scl_s, scl_m, scl};
      {sda_p, sda_s, sda_m} <= {sda_s, sda_m, sda};
      if (!pwr_dn_n) begin
        active   <= 1'b0;
        bitcnt   <= '0;
        bytecnt  <= '0;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        active   <= 1'b1;
        bitcnt   <= '0;
        bytecnt  <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        active   <= 1'b0;
        bitcnt   <= '0;
        bytecnt  <= '0;
        sda_pull <= 1'b0;
      end else if (active && scl_rise && bitcnt < 4'd8) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end else if (active && scl_fall) begin
        if (bitcnt == 4'd8) begin
          bitcnt   <= 4'd9;
          sda_pull <= accept;
          if (is_addr && !accept) active <= 1'b0;
          if (do_store) ctl_regs[8*int'(widx) +: 8] <= shreg;
          if (bytecnt != SAT) bytecnt <= bytecnt + CW'(1);
        end else if (bitcnt == 4'd9) begin
          bitcnt   <= '0;
          sda_pull <= 1'b0;
        end
      end
    end
  end
endmodule

module wo_ctl_slave_chk #(
  parameter int NREG = 8,
  parameter int FRAME = 2,
  parameter int CW = 4
) (
  input logic              clk,
  input logic              por_n,
  input logic              pwr_dn_n,
  input logic              scl_s,
  input logic              stop_det,
  input logic              active,
  input logic              sda_pull,
  input logic [CW-1:0]     bytecnt,
  input logic [NREG*8-1:0] ctl_regs
);
  a_r4_ack_rises_scl_low: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sda_pull) |-> !scl_s);
  a_r8_pd_no_ack: assert property (@(posedge clk) disable iff (!por_n)
    !pwr_dn_n |=> !sda_pull);
  a_r8_pd_regs_hold: assert property (@(posedge clk) disable iff (!por_n)
    !pwr_dn_n |=> $stable(ctl_regs));
  a_r2_stop_idle: assert property (@(posedge clk) disable iff (!por_n)
    (stop_det && pwr_dn_n) |=> !active && !sda_pull);
  a_r7_write_window: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(ctl_regs) |-> (int'($past(bytecnt)) > FRAME && int'($past(bytecnt)) <= FRAME + NREG));
endmodule

bind wo_ctl_slave wo_ctl_slave_chk #(.NREG(NREG), .FRAME(FRAME), .CW(CW)) u_chk (
  .clk(clk), .por_n(por_n), .pwr_dn_n(pwr_dn_n), .scl_s(scl_s),
  .stop_det(stop_det), .active(active), .sda_pull(sda_pull),
  .bytecnt(bytecnt), .ctl_regs(ctl_regs));

// File: tb/tb_wo_ctl_slave.sv
module tb_wo_ctl_slave;
  logic clk = 0, por_n = 0, pwr_dn_n = 1, scl = 1, sda_m = 1;
  logic sda_pull;
  logic [63:0] ctl_regs;
  wire sda = sda_m & ~sda_pull;
  int vectors = 0, fails = 0, quiet = 20, cycles = 0;
  localparam int HALF = 12;

  logic [7:0] exp_r [8];
  logic exp_ack = 0;
  bit m_active = 0, m_pd = 0;
  int m_cnt = 0;

  wo_ctl_slave dut (.clk(clk), .por_n(por_n), .pwr_dn_n(pwr_dn_n), .scl(scl),
                    .sda(sda), .sda_pull(sda_pull), .ctl_regs(ctl_regs));

  always #10 clk = ~clk;

  function automatic logic [63:0] exp_flat();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = exp_r[k];
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (quiet > 0) quiet--;
  end

  always @(negedge clk) if (quiet == 0 && por_n) begin
    vectors++;
    if (ctl_regs !== exp_flat() || sda_pull !== exp_ack) begin
      fails++;
      $display("FAIL per-cycle (R4 R5 R6 R7): regs=%h ack=%b expected regs=%h ack=%b",
               ctl_regs, sda_pull, exp_flat(), exp_ack);
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] expv, input string req);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic drive(input logic c, input logic d);
    scl = c; sda_m = d; quiet = 6;
    wait_cyc(HALF);
  endtask

  task automatic do_start();
    drive(0, 1); drive(1, 1); drive(1, 0);
    if (!m_pd) begin m_active = 1; m_cnt = 0; end
    drive(0, 0);
  endtask

  task automatic do_stop();
    drive(0, 0); drive(1, 0);
    if (!m_pd) begin m_active = 0; m_cnt = 0; end
    drive(1, 1);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      drive(0, b[i]);
      scl = 1; quiet = 6; wait_cyc(HALF / 2);
      chk({63'd0, sda_pull}, 64'd0, "R4 no ack during data bit");
      wait_cyc(HALF - HALF / 2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit acc;
    send_bits(b, 8);
    scl = 0; quiet = 6;
    acc = 0;
    if (m_active && !m_pd) begin
      if (m_cnt == 0) begin
        acc = (b == 8'hD2);
        if (!acc) m_active = 0;
      end else if (m_cnt <= 10) begin
        acc = 1;
        if (m_cnt >= 3) exp_r[m_cnt - 3] = b;
      end
      m_cnt++;
    end
    exp_ack = acc;
    wait_cyc(HALF);
    sda_m = 1; quiet = 6; wait_cyc(HALF);
    scl = 1; quiet = 6; wait_cyc(HALF / 2);
    acked = !sda;
    wait_cyc(HALF - HALF / 2);
    scl = 0; exp_ack = 0; quiet = 6;
    wait_cyc(HALF);
  endtask

  task automatic frame_write(input logic [7:0] addr, input int nd, input logic [7:0] base,
                             output int nack);
    bit a;
    nack = 0;
    do_start();
    send_byte(addr, a); nack += int'(a);
    send_byte(8'h5A, a); nack += int'(a);
    send_byte(8'hA5, a); nack += int'(a);
    for (int i = 0; i < nd; i++) begin
      send_byte(base + 8'(i), a); nack += int'(a);
    end
    do_stop();
  endtask

  initial begin
    int n;
    bit a;
    logic [63:0] snap;
    exp_r = '{8'h0C, 8'hCF, 8'h7F, 8'hFF, 8'h00, 8'h37, 8'h00, 8'h07};
    wait_cyc(5);
    por_n = 1; quiet = 4;
    wait_cyc(6);
    chk(ctl_regs, 64'h07_00_37_00_FF_7F_CF_0C, "R1 defaults");
    chk({63'd0, sda_pull}, 64'd0, "R1 ack idle");

    frame_write(8'hD2, 3, 8'hA0, n);
    chk(64'(n), 64'd6, "R5 framing bytes and data acked");
    chk(ctl_regs, 64'h07_00_37_00_FF_A2_A1_A0, "R6 partial write order");

    frame_write(8'hD0, 2, 8'h11, n);
    chk(64'(n), 64'd0, "R3 wrong address no ack");
    frame_write(8'hD3, 2, 8'h22, n);
    chk(64'(n), 64'd0, "R3 read address no ack");
    chk(ctl_regs, 64'h07_00_37_00_FF_A2_A1_A0, "R3 nothing stored");

    frame_write(8'hD2, 9, 8'h30, n);
    chk(64'(n), 64'd11, "R7 only ten bytes acked");
    chk(ctl_regs, 64'h37_36_35_34_33_32_31_30, "R7 eleventh byte not stored");

    send_byte(8'hD2, a);
    chk(64'(a), 64'd0, "R2 no ack after stop without start");

    pwr_dn_n = 0; m_pd = 1; m_active = 0; m_cnt = 0; exp_ack = 0; quiet = 6;
    wait_cyc(10);
    frame_write(8'hD2, 4, 8'h90, n);
    chk(64'(n), 64'd0, "R8 no ack in power-down");
    chk(ctl_regs, 64'h37_36_35_34_33_32_31_30, "R8 registers kept");
    pwr_dn_n = 1; m_pd = 0; quiet = 6;
    wait_cyc(10);
    frame_write(8'hD2, 1, 8'hE7, n);
    chk(64'(n), 64'd4, "R8 works after release");
    chk(ctl_regs, 64'h37_36_35_34_33_32_31_E7, "R8 write after release");

    do_start();
    send_bits(8'hFF, 3);
    do_start();
    send_byte(8'hD2, a);
    chk(64'(a), 64'd1, "R9 restart address acked");
    send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h4C, a); send_byte(8'h6D, a);
    do_stop();
    chk(ctl_regs, 64'h37_36_35_34_33_32_6D_4C, "R9 data after restart");

    wait_cyc(20);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog (R2): actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule